// File: doc/BRIEF.md
# Progressive-Scan Frame Readout Sequencer

This block produces the readout timing for a 640 x 480 pixel array scanned progressively. For each frame it gives the column and row address of every pixel inside a programmable window, one pixel per clock. It also produces a frame envelope, a per-line valid strobe and a one-cycle pulse when the frame ends. Frames repeat without a break from the moment reset is released.

Every frame opens with a frame overhead interval. Each line then opens with a row overhead interval. A two-bit speed code sets the length of both intervals. In skip mode the row overhead gets eight more clocks and the row address steps by two. The window start column and width are given in units of 8 columns. The start row and line count are given in rows. The block samples all window and mode inputs once, in the first cycle of the frame overhead. A window that would run past the array edge is cut short at that edge.

Top module: `frame_readout_seq`

## Requirements
- R1: While rst_n is low, frame_valid, line_valid and frame_done are 0, and col_addr and row_addr are 0.
- R2: The frame overhead, during which frame_valid is 0, lasts 192, 336, 624 or 1200 clocks for speed_code 0, 1, 2 or 3.
- R3: Before each line there are row-overhead clocks with frame_valid 1 and line_valid 0. There are 20, 24, 32 or 48 of them for speed_code 0, 1, 2 or 3, plus 8 when skip_mode is 1.
- R4: frame_done is a single-cycle pulse in the clock after the last pixel of a frame. The distance between pulses is overhead + lines x (row overhead + pixels per line).
- R5: line_valid is 1 only while pixels stream. The first column of each line is 8 x win_col_blk. col_addr rises by 1 each clock, and a line holds 8 x win_blk_cnt pixels. A count of 0 means one block.
- R6: The first row is win_row. row_addr steps by 1 per line, or by 2 when skip_mode is 1. The frame holds win_lines lines, and a count of 0 means one line.
- R7: Column windows are clipped. A start block at or beyond 80 is treated as 79. The width is cut so that the last column is at most 639.
- R8: Row windows are clipped. A start row beyond 479 is treated as 479. The line count is cut so that no row above 479 is read, in either step mode.
- R9: Input changes made after the first cycle of the frame overhead do not affect the current frame. They take effect in the next frame.
- R10: frame_valid stays 1 from the first row overhead to the last pixel of the frame, and line_valid is never 1 while frame_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_col_blk | input | 7 | Window start column, in 8-column blocks |
| win_blk_cnt | input | 7 | Window width, in 8-column blocks |
| win_row | input | 9 | Window start row |
| win_lines | input | 9 | Number of lines to read |
| speed_code | input | 2 | Selects the overhead lengths |
| skip_mode | input | 1 | Row skipping: step of 2 and longer row overhead |
| frame_valid | output | 1 | High across the lines of a frame |
| line_valid | output | 1 | High while pixel addresses stream |
| col_addr | output | 10 | Current column address |
| row_addr | output | 9 | Current row address |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The in-module assertions check four properties on every cycle. line_valid never appears outside frame_valid. Columns stay in the array and advance by one within a line. Each line starts on an 8-column boundary. frame_done stays one cycle wide and marks the falling edge of frame_valid. Other properties need whole-frame scenarios in the bench. These are the exact overhead lengths for each speed code, the clipped window edges, the row step and line count in skip mode, and the fact that a write made in the middle of a frame waits for the next frame.

// File: rtl/frame_readout_seq.sv
module frame_readout_seq #(
  parameter int COLS  = 640,
  parameter int ROWS  = 480,
  parameter int XSTEP = 8,
  parameter int XBW   = $clog2(COLS / XSTEP + 1),
  parameter int XW    = $clog2(COLS),
  parameter int YW    = $clog2(ROWS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [XBW-1:0] win_col_blk,
  input  logic [XBW-1:0] win_blk_cnt,
  input  logic [YW-1:0]  win_row,
  input  logic [YW-1:0]  win_lines,
  input  logic [1:0]     speed_code,
  input  logic           skip_mode,
  output logic           frame_valid,
  output logic           line_valid,
  output logic [XW-1:0]  col_addr,
  output logic [YW-1:0]  row_addr,
  output logic           frame_done
);
  localparam int NBLK = COLS / XSTEP;
  localparam int CW   = 11;

  typedef enum logic [1:0] {ST_FOT, ST_ROT, ST_PIX} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [YW-1:0] line_i;
  logic [XW-1:0] col_first_q, col_last_q;
  logic [YW-1:0] row_first_q, nlines_q;
  logic [1:0]    gran_q;
  logic          skip_q;

  int xs_i, wb_i, ys_i, avail_i, nl_i;
  always_comb begin
    xs_i = (int'(win_col_blk) >= NBLK) ? NBLK - 1 : int'(win_col_blk);
    wb_i = (win_blk_cnt == '0) ? 1 : int'(win_blk_cnt);
    if (wb_i > NBLK - xs_i) wb_i = NBLK - xs_i;
    ys_i = (int'(win_row) > ROWS - 1) ? ROWS - 1 : int'(win_row);
    avail_i = skip_mode ? (ROWS - ys_i + 1) / 2 : ROWS - ys_i;
    nl_i = (win_lines == '0) ? 1 : int'(win_lines);
    if (nl_i > avail_i) nl_i = avail_i;
  end

  logic [CW-1:0] fot_len, rot_len;
  always_comb begin
    case (gran_q)
      2'd3:    begin fot_len = CW'(1200); rot_len = CW'(48); end
      2'd2:    begin fot_len = CW'(624);  rot_len = CW'(32); end
      2'd1:    begin fot_len = CW'(336);  rot_len = CW'(24); end
      default: begin fot_len = CW'(192);  rot_len = CW'(20); end
    endcase
    if (skip_q) rot_len = rot_len + CW'(8);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_FOT; cnt <= '0; line_i <= '0;
      col_addr <= '0; row_addr <= '0; frame_done <= 1'b0;
      col_first_q <= '0; col_last_q <= '0; row_first_q <= '0;
      nlines_q <= '0; gran_q <= '0; skip_q <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        ST_FOT: begin
          if (cnt == '0) begin
            col_first_q <= XW'(xs_i * XSTEP);
            col_last_q  <= XW'((xs_i + wb_i) * XSTEP - 1);
            row_first_q <= YW'(ys_i);
            nlines_q    <= YW'(nl_i);
            gran_q      <= speed_code;
            skip_q      <= skip_mode;
          end
          if (cnt == fot_len - 1'b1) begin
            cnt <= '0; st <= ST_ROT; row_addr <= row_first_q; line_i <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_ROT: begin
          if (cnt == rot_len - 1'b1) begin
            cnt <= '0; st <= ST_PIX; col_addr <= col_first_q;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (col_addr == col_last_q) begin
            if (line_i == nlines_q - 1'b1) begin
              st <= ST_FOT; frame_done <= 1'b1;
            end else begin
              st <= ST_ROT; line_i <= line_i + 1'b1;
              row_addr <= row_addr + (skip_q ? YW'(2) : YW'(1));
            end
          end else col_addr <= col_addr + 1'b1;
        end
      endcase
    end
  end

  assign frame_valid = (st != ST_FOT);
  assign line_valid  = (st == ST_PIX);

  p_lv_inside_fv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> frame_valid);
  p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && $past(line_valid)) |-> (col_addr == $past(col_addr) + 1'b1));
  p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && $past(line_valid)) |-> $stable(row_addr));
  p_col_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_valid) |-> (col_addr[2:0] == 3'd0));
  p_in_array_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (int'(col_addr) < COLS && int'(row_addr) < ROWS));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_valid) |-> frame_done);
endmodule

// File: tb/frame_readout_seq_bench.sv
module frame_readout_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // xs, w, ys, nl, gran, skip, exp: xf, xl, yf, yl, n, fot, rot
  localparam int V[NV][13] = '{
    '{0,   2,  0,   3, 0, 0,   0,  15,   0,   2, 3,  192, 20},
    '{5,   1,  10,  2, 1, 0,  40,  47,  10,  11, 2,  336, 24},
    '{3,   2,  7,   4, 2, 1,  24,  39,   7,  13, 4,  624, 40},
    '{1,   1,  100, 2, 3, 0,   8,  15, 100, 101, 2, 1200, 48},
    '{78,  10, 478, 5, 0, 0, 624, 639, 478, 479, 2,  192, 20},
    '{0,   0,  0,   0, 1, 1,   0,   7,   0,   0, 1,  336, 32},
    '{100, 3,  475, 9, 0, 1, 632, 639, 475, 479, 3,  192, 28},
    '{2,   1,  479, 4, 3, 1,  16,  23, 479, 479, 1, 1200, 56}
  };

  logic clk = 0, rst_n = 0;
  logic [6:0] win_col_blk = 0, win_blk_cnt = 1;
  logic [8:0] win_row = 0, win_lines = 1;
  logic [1:0] speed_code = 0;
  logic skip_mode = 0;
  logic frame_valid, line_valid, frame_done;
  logic [9:0] col_addr;
  logic [8:0] row_addr;
  int checks = 0, fails = 0, cyc = 0;
  int poke_at = -1, poke_v = 0;
  int m_xf, m_xl, m_yf, m_yl, m_n, m_fot, m_rot, m_per, m_stepbad;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_readout_seq u_frame_readout_seq (
    .clk(clk), .rst_n(rst_n), .win_col_blk(win_col_blk), .win_blk_cnt(win_blk_cnt),
    .win_row(win_row), .win_lines(win_lines), .speed_code(speed_code),
    .skip_mode(skip_mode), .frame_valid(frame_valid), .line_valid(line_valid),
    .col_addr(col_addr), .row_addr(row_addr), .frame_done(frame_done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int i);
    win_col_blk = 7'(V[i][0]); win_blk_cnt = 7'(V[i][1]);
    win_row = 9'(V[i][2]); win_lines = 9'(V[i][3]);
    speed_code = 2'(V[i][4]); skip_mode = V[i][5][0];
  endtask

  // Measures one frame, starting at the frame_done cycle that opens it.
  task automatic measure();
    int c = 0; int first_fv = -1; bit prev_lv = 0; int prev_row = 0;
    int step;
    while (!frame_done) @(negedge clk);
    step = skip_mode ? 2 : 1;
    m_n = 0; m_stepbad = 0; m_per = -1;
    forever begin
      if (c == poke_at) apply(poke_v);
      if (frame_valid && first_fv < 0) first_fv = c;
      if (line_valid && !prev_lv) begin
        m_n = m_n + 1;
        if (m_n == 1) begin
          m_xf = int'(col_addr); m_yf = int'(row_addr); m_rot = c - first_fv;
        end else if (int'(row_addr) != prev_row + step) m_stepbad = m_stepbad + 1;
        prev_row = int'(row_addr);
      end
      if (line_valid) begin
        m_yl = int'(row_addr);
        if (m_n == 1) m_xl = int'(col_addr);
      end
      if (c > 0 && frame_done) begin m_per = c; break; end
      prev_lv = line_valid; c = c + 1;
      @(negedge clk);
    end
    m_fot = first_fv;
  endtask

  task automatic compare(input int i);
    chk("R2 frame overhead", m_fot, V[i][11]);
    chk("R3 row overhead", m_rot, V[i][12]);
    chk((i == 4 || i == 6) ? "R7 first column clipped" : "R5 first column", m_xf, V[i][6]);
    chk((i == 4 || i == 6) ? "R7 last column clipped" : "R5 last column", m_xl, V[i][7]);
    chk("R6 first row", m_yf, V[i][8]);
    chk((i >= 4) ? "R8 last row clipped" : "R6 last row", m_yl, V[i][9]);
    chk("R6 line count", m_n, V[i][10]);
    chk("R6 row step", m_stepbad, 0);
    chk("R4 frame period", m_per, V[i][11] + V[i][10] * (V[i][12] + V[i][7] - V[i][6] + 1));
  endtask

  initial begin
    apply(0);
    repeat (3) @(negedge clk);
    chk("R1 frame_valid in reset", int'(frame_valid), 0);
    chk("R1 line_valid in reset", int'(line_valid), 0);
    chk("R1 frame_done in reset", int'(frame_done), 0);
    chk("R1 col_addr in reset", int'(col_addr), 0);
    chk("R1 row_addr in reset", int'(row_addr), 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      apply(i);
      measure();
      compare(i);
    end
    // R9: change the inputs during the frame overhead, after the latch cycle
    apply(1);
    poke_at = 100; poke_v = 2;
    measure();
    poke_at = -1;
    chk("R9 first row kept", m_yf, V[1][8]);
    chk("R9 row overhead kept", m_rot, V[1][12]);
    chk("R9 period kept", m_per, V[1][11] + V[1][10] * (V[1][12] + 8));
    measure();
    chk("R9 new first row next frame", m_yf, V[2][8]);
    chk("R9 new row overhead next frame", m_rot, V[2][12]);
    // R10: frame_valid stays high from the first row overhead to the end of the frame
    apply(0);
    while (!frame_done) @(negedge clk);
    repeat (192) @(negedge clk);
    begin
      int low = 0;
      for (int k = 0; k < 3 * 36; k++) begin
        if (!frame_valid) low = low + 1;
        @(negedge clk);
      end
      chk("R10 frame_valid gaps inside frame", low, 0);
    end
    chk("R10 frame_valid low after frame", int'(frame_valid), 0);
    chk("R4 frame_done after last pixel", int'(frame_done), 1);
    @(negedge clk);
    chk("R4 frame_done one cycle", int'(frame_done), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule